// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block writes one page into a group of four NAND flash chips that share their data lines, write strobe and latch-enable lines. Each chip has its own chip-enable and ready/busy input. After a start pulse the block takes the page row address from the host. It then walks the asynchronous flash bus through a short idle slot, the data-input command, two column and three row address cycles, the full page of data bytes and the program-confirm command. The data bytes are the main area first and the spare area after it. The block pulls bytes from the host one at a time, one pulse of `byteTake` per byte placed on the bus.

Once the confirm command is on the bus, a monitor follows the four ready/busy lines together. A chip is settled once one of three things happens. It goes busy and then returns ready. It never goes busy within a short window, and is dropped from the wait. It stays busy past the program-time limit, and is flagged as failed. When all four chips are settled, the block pulses `done` and presents a per-chip failure vector. A single bad chip therefore never stalls the recording stream.

Every bus slot lasts ten core cycles: the write strobe is low for five and high for five, and the flash latches on the rising edge. Page size, strobe timing, address cycle counts, the busy-detect window and the program timeout are all parameters.

Top module: `nand_page_prog`

## Requirements
- R1: After reset and while idle, every `ceN` bit is 1, `weN` and `reN` are 1, `cle`, `ale`, `ioOe` and `done` are 0, and `chipFail` is 0.
- R2: The first bus slot of an operation carries 0x80 on `ioOut` with `cle`=1 and `ale`=0.
- R3: The next five slots carry address bytes with `ale`=1 and `cle`=0. The first two are column bytes of value 0x00. The last three are the row address, least significant byte first (`pageAddr[7:0]`, then `[15:8]`, then `[23:16]`).
- R4: The next MAIN_BYTES+SPARE_BYTES slots carry the host bytes in stream order with `cle`=`ale`=0, and `byteTake` pulses exactly once per byte.
- R5: In every slot `weN` is low for STROBE_LOW cycles and then high for STROBE_HIGH cycles. `ioOut`, `cle` and `ale` do not change while `weN` is low.
- R6: The final slot carries 0x10 with `cle`=1. No further slot follows before `done`.
- R7: When every chip goes busy and later returns ready, `done` follows the last chip to return, `chipFail` is 0, and all `ceN` bits and `weN` are 1 when `done` is high.
- R8: A chip whose ready/busy line does not fall within BUSY_WIN cycles of the confirm is dropped. It raises no failure bit, and `done` comes without waiting for the timeout.
- R9: A chip that goes busy and stays busy raises its own `chipFail` bit. `done` then comes no earlier than TIMEOUT_CYC cycles after the confirm.
- R10: `done` lasts one cycle. `chipFail` holds its value until the next accepted start, which clears it.
- R11: A start pulse while an operation is running is ignored, and the operation completes with exactly the expected slot sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to program a page |
| pageAddr | input | 8*ROW_CYCLES | Row address, captured at start |
| dataIn | input | 8 | Current stream byte, held until `byteTake` |
| byteTake | output | 1 | One-cycle pulse: current byte consumed |
| done | output | 1 | One-cycle pulse: operation complete |
| chipFail | output | NUM_CHIPS | Per-chip program timeout flags |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low, held inactive |
| ceN | output | NUM_CHIPS | Per-chip enables, active low |
| ioOut | output | 8 | Flash data/command/address byte |
| ioOe | output | 1 | Output enable for `ioOut` |
| rbN | input | NUM_CHIPS | Per-chip ready/busy, low means busy |

## Verification
The hardest situations to reach are the mixed endings, where chips in one group behave differently after the confirm command. In such a run one chip may never go busy while another stays busy, and the block must keep those two outcomes apart. The bench plays the flash side itself. It counts cycles from the observed rising strobe of the confirm slot and drives each chip's ready/busy line according to a per-chip mode (normal with staggered busy lengths, never busy, stuck busy). It then checks both the failure vector and the cycle in which `done` arrives against the window and the shortened timeout.

// File: rtl/npp_pkg.sv
package npp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_CMD1, ST_ADDR, ST_DATA, ST_CMD2, ST_WAIT, ST_DONE
  } seqState_e;

  typedef enum logic [2:0] {
    CH_OFF, CH_ARM, CH_BUSY, CH_OK, CH_DROP, CH_FAIL
  } chipState_e;

  typedef struct packed {
    logic       capture;
    logic       ceOn;
    logic       cleOn;
    logic       aleOn;
    logic       weLow;
    logic       oeOn;
    logic       loadCmdIn;
    logic       loadCmdGo;
    logic       loadAddr;
    logic [2:0] addrIdx;
    logic       loadData;
    logic       monStart;
    logic       finish;
  } busCtl_t;

  localparam logic [7:0] CMD_DATA_IN = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'h10;

endpackage

// File: rtl/npp_ctrl.sv
module npp_ctrl
  import npp_pkg::*;
#(
  parameter int STROBE_LOW  = 5,
  parameter int STROBE_HIGH = 5,
  parameter int ADDR_CYCLES = 5,
  parameter int PAGE_BYTES  = 8640
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    monDone,
  output busCtl_t ctl
);
  localparam int SLOT_LEN = STROBE_LOW + STROBE_HIGH;
  localparam int SLOT_W   = $clog2(SLOT_LEN + 1);
  localparam int IDX_W    = $clog2(PAGE_BYTES + ADDR_CYCLES + 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_LEN - 1);
  localparam logic [SLOT_W-1:0] LOW_END   = SLOT_W'(STROBE_LOW);
  localparam logic [IDX_W-1:0]  ADDR_LAST = IDX_W'(ADDR_CYCLES - 1);
  localparam logic [IDX_W-1:0]  DATA_LAST = IDX_W'(PAGE_BYTES - 1);

  seqState_e          state;
  logic [SLOT_W-1:0]  slotCnt;
  logic [IDX_W-1:0]   idx;
  logic               slotted, busSlot, slotEnd, slotHead;

  assign busSlot  = state inside {ST_CMD1, ST_ADDR, ST_DATA, ST_CMD2};
  assign slotted  = busSlot || (state == ST_PRE);
  assign slotEnd  = slotted && (slotCnt == SLOT_LAST);
  assign slotHead = busSlot && (slotCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slotCnt <= '0;
      idx     <= '0;
    end else begin
      slotCnt <= (slotted && !slotEnd) ? slotCnt + 1'b1 : '0;
      case (state)
        ST_IDLE: begin
          idx <= '0;
          if (start) state <= ST_PRE;
        end
        ST_PRE:  if (slotEnd) state <= ST_CMD1;
        ST_CMD1: if (slotEnd) begin
          state <= ST_ADDR;
          idx   <= '0;
        end
        ST_ADDR: if (slotEnd) begin
          if (idx == ADDR_LAST) begin
            state <= ST_DATA;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_DATA: if (slotEnd) begin
          if (idx == DATA_LAST) state <= ST_CMD2;
          else                  idx   <= idx + 1'b1;
        end
        ST_CMD2: if (slotEnd) state <= ST_WAIT;
        ST_WAIT: if (monDone) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.capture   = (state == ST_IDLE) && start;
    ctl.ceOn      = slotted || (state == ST_WAIT);
    ctl.cleOn     = (state == ST_CMD1) || (state == ST_CMD2);
    ctl.aleOn     = (state == ST_ADDR);
    ctl.oeOn      = busSlot;
    ctl.weLow     = busSlot && (slotCnt < LOW_END);
    ctl.loadCmdIn = slotHead && (state == ST_CMD1);
    ctl.loadCmdGo = slotHead && (state == ST_CMD2);
    ctl.loadAddr  = slotHead && (state == ST_ADDR);
    ctl.addrIdx   = 3'(idx);
    ctl.loadData  = slotHead && (state == ST_DATA);
    ctl.monStart  = slotEnd && (state == ST_CMD2);
    ctl.finish    = (state == ST_DONE);
  end

endmodule

// File: rtl/npp_dpath.sv
module npp_dpath
  import npp_pkg::*;
#(
  parameter int NUM_CHIPS  = 4,
  parameter int COL_CYCLES = 2,
  parameter int ROW_CYCLES = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  busCtl_t                 ctl,
  input  logic [8*ROW_CYCLES-1:0] pageAddr,
  input  logic [7:0]              dataIn,
  input  logic [NUM_CHIPS-1:0]    failVec,
  output logic [7:0]              ioOut,
  output logic                    ioOe,
  output logic                    cle,
  output logic                    ale,
  output logic                    weN,
  output logic                    reN,
  output logic [NUM_CHIPS-1:0]    ceN,
  output logic                    byteTake,
  output logic                    done,
  output logic [NUM_CHIPS-1:0]    chipFail
);
  localparam int ROW_W = 8 * ROW_CYCLES;

  logic [ROW_W-1:0] pageReg;
  logic [7:0]       addrByte;

  assign reN = 1'b1;

  always_comb begin
    addrByte = 8'h00;
    for (int r = 0; r < ROW_CYCLES; r++) begin
      if (int'(ctl.addrIdx) == COL_CYCLES + r) addrByte = pageReg[8*r +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioOut    <= '0;
      ioOe     <= 1'b0;
      cle      <= 1'b0;
      ale      <= 1'b0;
      weN      <= 1'b1;
      ceN      <= '1;
      byteTake <= 1'b0;
      done     <= 1'b0;
      chipFail <= '0;
      pageReg  <= '0;
    end else begin
      cle      <= ctl.cleOn;
      ale      <= ctl.aleOn;
      weN      <= !ctl.weLow;
      ceN      <= {NUM_CHIPS{!ctl.ceOn}};
      ioOe     <= ctl.oeOn;
      byteTake <= ctl.loadData;
      done     <= ctl.finish;
      if (ctl.capture) begin
        pageReg  <= pageAddr;
        chipFail <= '0;
      end else if (ctl.finish) begin
        chipFail <= failVec;
      end
      if (ctl.loadCmdIn)      ioOut <= CMD_DATA_IN;
      else if (ctl.loadCmdGo) ioOut <= CMD_CONFIRM;
      else if (ctl.loadAddr)  ioOut <= addrByte;
      else if (ctl.loadData)  ioOut <= dataIn;
    end
  end

endmodule

// File: rtl/npp_rbmon.sv
module npp_rbmon
  import npp_pkg::*;
#(
  parameter int NUM_CHIPS   = 4,
  parameter int TIMEOUT_CYC = 260000,
  parameter int BUSY_WIN    = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 monStart,
  input  logic [NUM_CHIPS-1:0] rbN,
  output logic                 allDone,
  output logic [NUM_CHIPS-1:0] failVec
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(BUSY_WIN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TIMEOUT_CYC);

  logic [NUM_CHIPS-1:0] rbMeta, rbSync, resolvedV;
  logic [CNT_W-1:0]     waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbMeta  <= '1;
      rbSync  <= '1;
      waitCnt <= '0;
    end else begin
      rbMeta <= rbN;
      rbSync <= rbMeta;
      if (monStart)               waitCnt <= '0;
      else if (waitCnt != CNT_MAX) waitCnt <= waitCnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_chip
    chipState_e st;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st <= CH_OFF;
      end else if (monStart) begin
        st <= CH_ARM;
      end else begin
        case (st)
          CH_ARM: begin
            if (!rbSync[g])              st <= CH_BUSY;
            else if (waitCnt >= WIN_LAST) st <= CH_DROP;
          end
          CH_BUSY: begin
            if (rbSync[g])               st <= CH_OK;
            else if (waitCnt >= TO_LAST) st <= CH_FAIL;
          end
          default: st <= st;
        endcase
      end
    end
    assign resolvedV[g] = st inside {CH_OK, CH_DROP, CH_FAIL};
    assign failVec[g]   = (st == CH_FAIL);
  end

  assign allDone = &resolvedV;

endmodule

// File: rtl/nand_page_prog.sv
module nand_page_prog
  import npp_pkg::*;
#(
  parameter int NUM_CHIPS   = 4,
  parameter int MAIN_BYTES  = 8192,
  parameter int SPARE_BYTES = 448,
  parameter int STROBE_LOW  = 5,
  parameter int STROBE_HIGH = 5,
  parameter int COL_CYCLES  = 2,
  parameter int ROW_CYCLES  = 3,
  parameter int TIMEOUT_CYC = 260000,
  parameter int BUSY_WIN    = 1000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [8*ROW_CYCLES-1:0] pageAddr,
  input  logic [7:0]              dataIn,
  output logic                    byteTake,
  output logic                    done,
  output logic [NUM_CHIPS-1:0]    chipFail,
  output logic                    cle,
  output logic                    ale,
  output logic                    weN,
  output logic                    reN,
  output logic [NUM_CHIPS-1:0]    ceN,
  output logic [7:0]              ioOut,
  output logic                    ioOe,
  input  logic [NUM_CHIPS-1:0]    rbN
);
  localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
  localparam int ADDR_CYCLES = COL_CYCLES + ROW_CYCLES;

  busCtl_t              ctl;
  logic                 monDone;
  logic [NUM_CHIPS-1:0] failVec;

  npp_ctrl #(
    .STROBE_LOW (STROBE_LOW),
    .STROBE_HIGH(STROBE_HIGH),
    .ADDR_CYCLES(ADDR_CYCLES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .monDone(monDone),
    .ctl    (ctl)
  );

  npp_dpath #(
    .NUM_CHIPS (NUM_CHIPS),
    .COL_CYCLES(COL_CYCLES),
    .ROW_CYCLES(ROW_CYCLES)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .pageAddr(pageAddr),
    .dataIn  (dataIn),
    .failVec (failVec),
    .ioOut   (ioOut),
    .ioOe    (ioOe),
    .cle     (cle),
    .ale     (ale),
    .weN     (weN),
    .reN     (reN),
    .ceN     (ceN),
    .byteTake(byteTake),
    .done    (done),
    .chipFail(chipFail)
  );

  npp_rbmon #(
    .NUM_CHIPS  (NUM_CHIPS),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .BUSY_WIN   (BUSY_WIN)
  ) u_rbmon (
    .clk     (clk),
    .rstN    (rstN),
    .monStart(ctl.monStart),
    .rbN     (rbN),
    .allDone (monDone),
    .failVec (failVec)
  );

endmodule

// File: rtl/npp_checker.sv
module npp_checker #(
  parameter int NUM_CHIPS  = 4,
  parameter int STROBE_LOW = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 done,
  input logic [NUM_CHIPS-1:0] chipFail,
  input logic [NUM_CHIPS-1:0] ceN,
  input logic                 cle,
  input logic                 ale,
  input logic                 weN,
  input logic                 ioOe,
  input logic [7:0]           ioOut
);
  localparam int RUN_W = $clog2(STROBE_LOW + 2);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(STROBE_LOW + 1);

  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lowRun <= '0;
    else if (weN)            lowRun <= '0;
    else if (lowRun != RUN_SAT) lowRun <= lowRun + 1'b1;
  end

  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> lowRun == RUN_W'(STROBE_LOW));

  p_bus_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && $past(!weN)) |-> ($stable(ioOut) && $stable(cle) && $stable(ale)));

  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));

  p_drive_on_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (ioOe && ceN == '0));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_fail_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !$past(start)) |-> $stable(chipFail));

  p_release_at_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ceN == '1 && weN));

endmodule

bind nand_page_prog npp_checker #(
  .NUM_CHIPS (NUM_CHIPS),
  .STROBE_LOW(STROBE_LOW)
) u_npp_checker (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .done    (done),
  .chipFail(chipFail),
  .ceN     (ceN),
  .cle     (cle),
  .ale     (ale),
  .weN     (weN),
  .ioOe    (ioOe),
  .ioOut   (ioOut)
);

// File: tb/tb_nand_page_prog.sv
module tb_nand_page_prog;
  localparam int NCH   = 4;
  localparam int MAINB = 12;
  localparam int SPAREB = 4;
  localparam int PAGEB = MAINB + SPAREB;
  localparam int TO    = 400;
  localparam int WIN   = 40;
  localparam int SLOTS = 1 + 5 + PAGEB + 1;
  localparam int BUSY0 = 60;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] pageAddr = '0;
  logic [7:0]  dataIn;
  logic [3:0]  rbN = 4'hF;
  logic        byteTake, done, cle, ale, weN, reN, ioOe;
  logic [3:0]  chipFail, ceN;
  logic [7:0]  ioOut;

  always #4 clk = ~clk;

  nand_page_prog #(
    .NUM_CHIPS(NCH), .MAIN_BYTES(MAINB), .SPARE_BYTES(SPAREB),
    .STROBE_LOW(5), .STROBE_HIGH(5), .COL_CYCLES(2), .ROW_CYCLES(3),
    .TIMEOUT_CYC(TO), .BUSY_WIN(WIN)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .pageAddr(pageAddr), .dataIn(dataIn),
    .byteTake(byteTake), .done(done), .chipFail(chipFail), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .ceN(ceN), .ioOut(ioOut), .ioOe(ioOe), .rbN(rbN)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [7:0] srcBytes [16];
  int takeCnt = 0;
  int takeBase = 0;
  assign dataIn = srcBytes[4'(takeCnt - takeBase)];

  logic [9:0] busLog [256];
  int   logCnt = 0;
  int   logBase = 0;
  logic prevWe = 1'b1;
  int   lowLen = 0;
  int   highLen = 0;
  int   widthErr = 0;
  bit   inBurst = 1'b0;

  always @(negedge clk) begin
    if (byteTake) takeCnt++;
    if (!weN) begin
      if (prevWe && inBurst && highLen != 5) widthErr++;
      lowLen++;
    end else begin
      if (!prevWe) begin
        busLog[logCnt % 256] = {cle, ale, ioOut};
        if (lowLen != 5) widthErr++;
        inBurst = 1'b1;
        highLen = 0;
        lowLen = 0;
        logCnt++;
      end
      highLen++;
    end
    if (ceN == 4'hF) inBurst = 1'b0;
    prevWe = weN;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // modes: two bits per chip, 0 = normal, 1 = never busy, 2 = stuck busy
  task automatic runOp(input logic [23:0] page, input logic [7:0] seed, input logic [7:0] modes,
                       input bit midStart, input logic [3:0] expFail, input string tag,
                       output int doneAt);
    int guard, nDone, w0, mism;
    bit pulsed;
    logic [1:0] md;
    logic [3:0] failAtDone;
    logic [7:0] expB;
    for (int i = 0; i < 16; i++) srcBytes[i] = seed ^ 8'(i * 29);
    takeBase = takeCnt;
    logBase = logCnt;
    w0 = widthErr;
    @(negedge clk);
    pageAddr = page;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(chipFail == 4'h0, "R10 fail cleared by start", 32'(chipFail), 0);
    pulsed = 1'b0;
    guard = 0;
    while ((logCnt - logBase) < SLOTS && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (midStart && !pulsed && (logCnt - logBase) == 10) begin
        start = 1'b1;
        pulsed = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    doneAt = -1;
    nDone = 0;
    failAtDone = '0;
    for (int c = 1; c <= TO + 60; c++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        md = modes[2*k +: 2];
        if (md != 2'd1 && c == 3) rbN[k] = 1'b0;
        if (md == 2'd0 && c == 3 + BUSY0 + 5 * k) rbN[k] = 1'b1;
      end
      if (done) begin
        nDone++;
        if (doneAt < 0) begin
          doneAt = c;
          failAtDone = chipFail;
        end
      end
    end
    rbN = 4'hF;
    chk(busLog[logBase % 256] == {2'b10, 8'h80}, "R2 data-input command",
        32'(busLog[logBase % 256]), 32'({2'b10, 8'h80}));
    for (int a = 0; a < 5; a++) begin
      expB = (a < 2) ? 8'h00 : page[8*(a-2) +: 8];
      chk(busLog[(logBase + 1 + a) % 256] == {2'b01, expB}, "R3 address cycle",
          32'(busLog[(logBase + 1 + a) % 256]), 32'({2'b01, expB}));
    end
    mism = 0;
    for (int i = 0; i < PAGEB; i++)
      if (busLog[(logBase + 6 + i) % 256] != {2'b00, srcBytes[i]}) mism++;
    chk(mism == 0, "R4 data bytes in order", 32'(mism), 0);
    chk((takeCnt - takeBase) == PAGEB, "R4 byteTake count", 32'(takeCnt - takeBase), 32'(PAGEB));
    chk(busLog[(logBase + SLOTS - 1) % 256] == {2'b10, 8'h10}, "R6 confirm command",
        32'(busLog[(logBase + SLOTS - 1) % 256]), 32'({2'b10, 8'h10}));
    chk((logCnt - logBase) == SLOTS, midStart ? "R11 slot count with stray start" : "R6 slot count",
        32'(logCnt - logBase), 32'(SLOTS));
    chk(widthErr == w0, "R5 strobe widths", 32'(widthErr - w0), 0);
    chk(nDone == 1, "R10 single done pulse", 32'(nDone), 1);
    chk(failAtDone == expFail, tag, 32'(failAtDone), 32'(expFail));
    chk(ceN == 4'hF && ioOe == 1'b0 && weN == 1'b1, "R7 bus released after done",
        32'({ceN, ioOe, weN}), 32'({4'hF, 1'b0, 1'b1}));
  endtask

  task automatic testReset();
    chk(ceN == 4'hF, "R1 ceN idle", 32'(ceN), 32'hF);
    chk(weN == 1'b1 && reN == 1'b1, "R1 strobes idle", 32'({weN, reN}), 32'h3);
    chk(cle == 1'b0 && ale == 1'b0 && ioOe == 1'b0, "R1 latches idle", 32'({cle, ale, ioOe}), 0);
    chk(done == 1'b0 && chipFail == 4'h0, "R1 status idle", 32'({done, chipFail}), 0);
  endtask

  task automatic testAllReady();
    int t;
    runOp(24'h123456, 8'h5A, 8'h00, 1'b0, 4'h0, "R7 no failures", t);
    chk(t >= 3 + BUSY0 + 15 && t < TO, "R7 done after slowest chip", 32'(t), 32'(3 + BUSY0 + 15));
  endtask

  task automatic testDroppedChip();
    int t;
    runOp(24'h0A0B0C, 8'hC3, 8'b00_01_00_00, 1'b1, 4'h0, "R8 dropped chip not flagged", t);
    chk(t >= WIN && t < TO, "R8 no timeout wait", 32'(t), 32'(WIN));
  endtask

  task automatic testStuckChip();
    int t;
    runOp(24'hFFFFFF, 8'h3C, 8'b00_00_10_00, 1'b0, 4'h2, "R9 stuck chip flagged", t);
    chk(t >= TO && t <= TO + 20, "R9 done at timeout", 32'(t), 32'(TO));
    repeat (30) @(negedge clk);
    chk(chipFail == 4'h2, "R10 fail held", 32'(chipFail), 32'h2);
  endtask

  task automatic testMixed();
    int t;
    runOp(24'hABCDEF, 8'h96, 8'b10_00_00_01, 1'b0, 4'h8, "R9 R8 mixed outcome", t);
    chk(t >= TO && t <= TO + 20, "R9 mixed done at timeout", 32'(t), 32'(TO));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual no completion expected completion");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testAllReady();
    testDroppedChip();
    testStuckChip();
    testMixed();
    repeat (5) @(negedge clk);
    report();
  end

endmodule